// File: doc/BRIEF.md
# Memory Polynomial Predistortion Filter

This block pre-distorts a stream of complex baseband samples so that a following power amplifier, whose gain compresses and whose response depends on past samples, produces a more linear result. Each accepted sample enters a three-deep history. For every sample in that history the block forms three basis terms: the sample itself, the sample scaled by its instantaneous power, and the sample scaled by the square of its power. The nine basis terms are combined with nine complex coefficients in a complex dot product. The sum is rounded and saturated to a signed 16-bit I and Q result, which is presented with a valid strobe.

The coefficients come from an external estimator over two wide ports. A load strobe captures them into a holding bank. The captured set moves into the working bank at the next accepted sample, so every output is computed from a single coherent set. After reset the working bank holds unity on the current-sample linear term and zero on all other terms, so the block passes samples through unchanged.

Top module: `mpPredistorter`

## Requirements
- R1: While reset is asserted, and after it until the first result, outValid is 0 and outI and outQ are 0.
- R2: With the reset coefficient set, every accepted sample reappears unchanged on outI and outQ.
- R3: A sample accepted on a clock edge where inValid is 1 gives its result at the second following edge, and outValid is 1 for exactly that cycle. Back-to-back samples give back-to-back results, and outValid is 0 in every other cycle.
- R4: The history shifts only on cycles where inValid is 1. Idle cycles between samples do not change which samples count as one and two samples old.
- R5: For a history sample x of age m (0 = newest), the power is p = floor((I² + Q²) / 2^15). The basis terms are t0 = x, t1 = floor(t0·p / 2^15) and t2 = floor(t1·p / 2^15), computed on I and Q separately. Term tk of age m uses coefficient index j = 3·k + m.
- R6: Coefficient j sits in bits [16·j+15 : 16·j] of coefI and coefQ as signed Q1.14 (16384 = 1.0). The output is yI = Σ(cI·tI − cQ·tQ) and yQ = Σ(cI·tQ + cQ·tI), rounded as floor((sum + 8192) / 2^14).
- R7: A rounded result above 32767 is output as 32767, and one below −32768 is output as −32768.
- R8: A set captured by coefLoad is first used by the first sample accepted in a later cycle. A sample accepted in the same cycle as the load still uses the previous set.
- R9: When several loads occur before the next sample, the set from the last load is used.
- R10: Changes on coefI and coefQ while coefLoad is 0 have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input sample strobe |
| inI | input | 16 | Input in-phase sample, signed Q15 |
| inQ | input | 16 | Input quadrature sample, signed Q15 |
| coefLoad | input | 1 | Capture strobe for the coefficient ports |
| coefI | input | 144 | Nine real coefficient parts, signed Q1.14, index j at bits 16j+15:16j |
| coefQ | input | 144 | Nine imaginary coefficient parts, same layout |
| outValid | output | 1 | Result strobe |
| outI | output | 16 | Predistorted in-phase result |
| outQ | output | 16 | Predistorted quadrature result |

## Verification
The coefficient load and the acceptance of a sample can fall on the same clock edge. That is the moment where a set could be torn or applied one sample early. The bench raises coefLoad and inValid together, with the working set deliberately very different from the new one. It then requires that sample's result to match the old set exactly and the next sample's result to match the new set. A separate pair of back-to-back loads before one sample confirms that only the later set is used.

// File: rtl/dpdPkg.sv
package dpdPkg;
  localparam int DATA_W   = 16;
  localparam int COEF_W   = 16;
  localparam int COEF_FRAC = 14;
  localparam int DEPTH    = 3;
  localparam int DEGREE   = 3;
  localparam int POW_FRAC = 15;

  typedef struct packed {
    logic shiftEn;
    logic loadShadow;
    logic commitCoef;
    logic outEn;
  } dpdStrobes_t;
endpackage

// File: rtl/dpdCtrl.sv
module dpdCtrl
  import dpdPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        coefLoad,
  output dpdStrobes_t strb,
  output logic        outValid
);
  logic pending;
  logic vldD1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending  <= 1'b0;
      vldD1    <= 1'b0;
      outValid <= 1'b0;
    end else begin
      if (coefLoad)     pending <= 1'b1;
      else if (inValid) pending <= 1'b0;
      vldD1    <= inValid;
      outValid <= vldD1;
    end
  end

  always_comb begin
    strb.shiftEn    = inValid;
    strb.loadShadow = coefLoad;
    strb.commitCoef = inValid & pending;
    strb.outEn      = vldD1;
  end

  // R3
  out_valid_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 2));

  // R8
  commit_needs_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !pending && !coefLoad) |=> !pending);
endmodule

// File: rtl/dpdDatapath.sv
module dpdDatapath
  import dpdPkg::*;
#(
  parameter int DataW    = DATA_W,
  parameter int CoefW    = COEF_W,
  parameter int CoefFrac = COEF_FRAC,
  parameter int Depth    = DEPTH,
  parameter int Degree   = DEGREE,
  parameter int PowFrac  = POW_FRAC,
  localparam int NTap    = Depth * Degree
)(
  input  logic                       clk,
  input  logic                       rstN,
  input  dpdStrobes_t                strb,
  input  logic signed [DataW-1:0]    inI,
  input  logic signed [DataW-1:0]    inQ,
  input  logic [NTap*CoefW-1:0]      coefI,
  input  logic [NTap*CoefW-1:0]      coefQ,
  output logic signed [DataW-1:0]    outI,
  output logic signed [DataW-1:0]    outQ
);
  localparam int TermW = DataW + Degree;
  localparam int PowW  = 2 * DataW;
  localparam int PwrW  = DataW + 2;
  localparam int MulW  = TermW + PwrW;
  localparam int ProdW = CoefW + TermW;
  localparam int AccW  = ProdW + $clog2(2 * NTap) + 1;

  localparam logic [CoefW-1:0] Unity = CoefW'(1) << CoefFrac;
  localparam logic [NTap-1:0][CoefW-1:0] UnityBank = {{((NTap-1)*CoefW){1'b0}}, Unity};
  localparam logic signed [AccW-1:0] Half = signed'(AccW'(1) << (CoefFrac - 1));
  localparam logic signed [AccW-1:0] MaxV = signed'(AccW'((1 << (DataW - 1)) - 1));
  localparam logic signed [AccW-1:0] MinV = -MaxV - signed'(AccW'(1));

  // sample history, index 0 newest
  logic [Depth-1:0][DataW-1:0] histI, histQ;
  // holding and working coefficient banks
  logic [NTap-1:0][CoefW-1:0] shI, shQ, actI, actQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      histI <= '0;
      histQ <= '0;
    end else if (strb.shiftEn) begin
      histI <= {histI[Depth-2:0], inI};
      histQ <= {histQ[Depth-2:0], inQ};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shI  <= UnityBank;
      shQ  <= '0;
      actI <= UnityBank;
      actQ <= '0;
    end else begin
      if (strb.loadShadow) begin
        shI <= coefI;
        shQ <= coefQ;
      end
      if (strb.commitCoef) begin
        actI <= shI;
        actQ <= shQ;
      end
    end
  end

  // basis terms, index j = k*Depth + m
  logic signed [TermW-1:0] bI [NTap];
  logic signed [TermW-1:0] bQ [NTap];

  for (genvar m = 0; m < Depth; m++) begin : g_age
    logic signed [PowW-1:0]  sqI, sqQ;
    logic        [PowW:0]    pwrSum;
    logic signed [PwrW-1:0]  pwr;

    assign sqI    = $signed(histI[m]) * $signed(histI[m]);
    assign sqQ    = $signed(histQ[m]) * $signed(histQ[m]);
    assign pwrSum = {1'b0, sqI} + {1'b0, sqQ};
    assign pwr    = signed'({1'b0, pwrSum[PowFrac+DataW:PowFrac]});

    assign bI[m] = TermW'($signed(histI[m]));
    assign bQ[m] = TermW'($signed(histQ[m]));

    for (genvar k = 1; k < Degree; k++) begin : g_ord
      logic signed [MulW-1:0] mulI, mulQ;
      assign mulI = bI[(k-1)*Depth + m] * pwr;
      assign mulQ = bQ[(k-1)*Depth + m] * pwr;
      assign bI[k*Depth + m] = mulI[PowFrac+TermW-1:PowFrac];
      assign bQ[k*Depth + m] = mulQ[PowFrac+TermW-1:PowFrac];
    end
  end

  // complex products per tap
  logic signed [ProdW-1:0] pII [NTap];
  logic signed [ProdW-1:0] pQQ [NTap];
  logic signed [ProdW-1:0] pIQ [NTap];
  logic signed [ProdW-1:0] pQI [NTap];

  for (genvar j = 0; j < NTap; j++) begin : g_tap
    assign pII[j] = $signed(actI[j]) * bI[j];
    assign pQQ[j] = $signed(actQ[j]) * bQ[j];
    assign pIQ[j] = $signed(actI[j]) * bQ[j];
    assign pQI[j] = $signed(actQ[j]) * bI[j];
  end

  logic signed [AccW-1:0] accI, accQ, rndI, rndQ;
  logic signed [DataW-1:0] satI, satQ;

  always_comb begin
    accI = '0;
    accQ = '0;
    for (int j = 0; j < NTap; j++) begin
      accI = accI + AccW'(pII[j]) - AccW'(pQQ[j]);
      accQ = accQ + AccW'(pIQ[j]) + AccW'(pQI[j]);
    end
    rndI = (accI + Half) >>> CoefFrac;
    rndQ = (accQ + Half) >>> CoefFrac;
    if (rndI > MaxV)      satI = MaxV[DataW-1:0];
    else if (rndI < MinV) satI = MinV[DataW-1:0];
    else                  satI = rndI[DataW-1:0];
    if (rndQ > MaxV)      satQ = MaxV[DataW-1:0];
    else if (rndQ < MinV) satQ = MinV[DataW-1:0];
    else                  satQ = rndQ[DataW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outI <= '0;
      outQ <= '0;
    end else if (strb.outEn) begin
      outI <= satI;
      outQ <= satQ;
    end
  end

  // R4
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shiftEn |=> ($stable(histI) && $stable(histQ)));

  // R8
  coef_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commitCoef |=> ($stable(actI) && $stable(actQ)));

  // R10
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadShadow |=> ($stable(shI) && $stable(shQ)));

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.outEn |=> ($stable(outI) && $stable(outQ)));
endmodule

// File: rtl/mpPredistorter.sv
module mpPredistorter
  import dpdPkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             inValid,
  input  logic signed [DATA_W-1:0]         inI,
  input  logic signed [DATA_W-1:0]         inQ,
  input  logic                             coefLoad,
  input  logic [DEPTH*DEGREE*COEF_W-1:0]   coefI,
  input  logic [DEPTH*DEGREE*COEF_W-1:0]   coefQ,
  output logic                             outValid,
  output logic signed [DATA_W-1:0]         outI,
  output logic signed [DATA_W-1:0]         outQ
);
  dpdStrobes_t strb;

  dpdCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .coefLoad (coefLoad),
    .strb     (strb),
    .outValid (outValid)
  );

  dpdDatapath #(
    .DataW    (DATA_W),
    .CoefW    (COEF_W),
    .CoefFrac (COEF_FRAC),
    .Depth    (DEPTH),
    .Degree   (DEGREE),
    .PowFrac  (POW_FRAC)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .inI   (inI),
    .inQ   (inQ),
    .coefI (coefI),
    .coefQ (coefQ),
    .outI  (outI),
    .outQ  (outQ)
  );
endmodule

// File: tb/sim_mpPredistorter.sv
module sim_mpPredistorter;
  localparam int ClkPeriod = 10;
  localparam int NT = 9;

  localparam logic [31:0] Vecs [12] = '{
    32'h0000_0000, 32'h1000_F000, 32'h7FFF_0000, 32'h8000_8000,
    32'h4000_4000, 32'hC000_2000, 32'h0123_FEDC, 32'h6000_A000,
    32'h0001_FFFF, 32'h3A98_C568, 32'hF830_07D0, 32'h5555_2AAA
  };

  logic clk = 0;
  logic rstN = 0;
  logic inValid = 0;
  logic signed [15:0] inI = 0, inQ = 0;
  logic coefLoad = 0;
  logic [NT*16-1:0] coefI = '0, coefQ = '0;
  logic outValid;
  logic signed [15:0] outI, outQ;

  int nChecks = 0, nFail = 0;
  bit done = 0;

  int hI[3], hQ[3];
  int aI[NT], aQ[NT], sI[NT], sQ[NT], nI[NT], nQ[NT];
  bit pend;

  always #(ClkPeriod/2) clk = ~clk;

  mpPredistorter u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inI(inI), .inQ(inQ),
    .coefLoad(coefLoad), .coefI(coefI), .coefQ(coefQ),
    .outValid(outValid), .outI(outI), .outQ(outQ));

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  task automatic modelOut(output int yI, output int yQ);
    longint accI = 0, accQ = 0;
    for (int m = 0; m < 3; m++) begin
      longint p = (longint'(hI[m]) * hI[m] + longint'(hQ[m]) * hQ[m]) >>> 15;
      longint tI = hI[m], tQ = hQ[m];
      for (int k = 0; k < 3; k++) begin
        int j = 3 * k + m;
        if (k > 0) begin
          tI = (tI * p) >>> 15;
          tQ = (tQ * p) >>> 15;
        end
        accI += longint'(aI[j]) * tI - longint'(aQ[j]) * tQ;
        accQ += longint'(aI[j]) * tQ + longint'(aQ[j]) * tI;
      end
    end
    yI = sat16((accI + 8192) >>> 14);
    yQ = sat16((accQ + 8192) >>> 14);
  endtask

  task automatic putPorts();
    for (int j = 0; j < NT; j++) begin
      coefI[j*16 +: 16] = nI[j][15:0];
      coefQ[j*16 +: 16] = nQ[j][15:0];
    end
  endtask

  // model step for one accepted sample, returns expected result
  task automatic accept(int i, int q, bit withLoad, output int yI, output int yQ);
    if (pend) begin
      aI = sI; aQ = sQ; pend = 0;
    end
    if (withLoad) begin
      sI = nI; sQ = nQ; pend = 1;
    end
    hI[2] = hI[1]; hQ[2] = hQ[1];
    hI[1] = hI[0]; hQ[1] = hQ[0];
    hI[0] = i;     hQ[0] = q;
    modelOut(yI, yQ);
  endtask

  task automatic loadNew();
    @(negedge clk);
    putPorts();
    coefLoad = 1;
    sI = nI; sQ = nQ; pend = 1;
    @(negedge clk);
    coefLoad = 0;
  endtask

  task automatic sendSample(int i, int q, bit withLoad, string req);
    int eI, eQ;
    @(negedge clk);
    inValid = 1; inI = 16'(i); inQ = 16'(q);
    if (withLoad) begin putPorts(); coefLoad = 1; end
    accept(i, q, withLoad, eI, eQ);
    @(negedge clk);
    inValid = 0; coefLoad = 0;
    check("R3 outValid early", int'(outValid), 0);
    @(negedge clk);
    check("R3 outValid", int'(outValid), 1);
    check({req, " outI"}, int'(outI), eI);
    check({req, " outQ"}, int'(outQ), eQ);
  endtask

  task automatic setZero();
    for (int j = 0; j < NT; j++) begin nI[j] = 0; nQ[j] = 0; end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int eI[6], eQ[6];
    for (int m = 0; m < 3; m++) begin hI[m] = 0; hQ[m] = 0; end
    for (int j = 0; j < NT; j++) begin aI[j] = 0; aQ[j] = 0; end
    aI[0] = 16384; sI = aI; sQ = aQ; pend = 0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 outValid in reset", int'(outValid), 0);
    check("R1 outI in reset", int'(outI), 0);
    rstN = 1;
    @(negedge clk);
    check("R1 outValid after reset", int'(outValid), 0);
    check("R1 outQ after reset", int'(outQ), 0);

    // R2: pass-through with reset coefficients
    for (int v = 0; v < 12; v++) begin
      sendSample(int'($signed(Vecs[v][31:16])), int'($signed(Vecs[v][15:0])), 0, "R2");
      check("R2 direct I", int'(outI), int'($signed(Vecs[v][31:16])));
    end

    // R5 R6: nonlinear memory set
    setZero();
    nI[0] = 16384; nQ[0] = 0;
    nI[1] = -2000; nQ[1] = 1000;
    nI[2] = 500;   nQ[2] = -300;
    nI[3] = -3000; nQ[3] = 800;
    nI[4] = 700;   nQ[4] = 200;
    nI[6] = 1200;  nQ[6] = -400;
    nI[8] = -250;  nQ[8] = 600;
    loadNew();
    for (int v = 0; v < 12; v++)
      sendSample(int'($signed(Vecs[v][31:16])), int'($signed(Vecs[v][15:0])), 0, "R5 R6");

    // R4: long idle gaps must not shift the history
    repeat (6) begin
      @(negedge clk);
      check("R4 R3 idle outValid", int'(outValid), 0);
    end
    sendSample(9000, -7000, 0, "R4");
    repeat (5) @(negedge clk);
    sendSample(-12000, 3000, 0, "R4");

    // R3: back-to-back stream
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      if (n >= 2) begin
        check("R3 stream valid", int'(outValid), 1);
        check("R3 stream I", int'(outI), eI[n-2]);
        check("R3 stream Q", int'(outQ), eQ[n-2]);
      end
      if (n < 4) begin
        inValid = 1;
        inI = 16'(int'($signed(Vecs[n+4][31:16])));
        inQ = 16'(int'($signed(Vecs[n+4][15:0])));
        accept(int'(inI), int'(inQ), 0, eI[n], eQ[n]);
      end else inValid = 0;
    end
    @(negedge clk);
    check("R3 stream ends", int'(outValid), 0);

    // R7: saturation
    setZero();
    nI[0] = 32767;
    loadNew();
    sendSample(30000, -30000, 0, "R7");
    check("R7 high clamp", int'(outI), 32767);
    check("R7 low clamp", int'(outQ), -32768);

    // R8: load in the same cycle as a sample
    setZero();
    nI[0] = 16384;
    sendSample(1000, 2000, 1, "R8 same cycle old set");
    check("R8 old set used", int'(outI), 2000);
    sendSample(1000, 2000, 0, "R8 new set next");
    check("R8 new set used", int'(outI), 1000);

    // R9: two loads, last wins
    setZero();
    nI[0] = 4000; nQ[0] = 9000;
    loadNew();
    setZero();
    nI[0] = 8192;
    loadNew();
    sendSample(6000, -4000, 0, "R9");
    check("R9 half gain", int'(outI), 3000);

    // R10: port activity without coefLoad
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      for (int j = 0; j < NT; j++) begin
        coefI[j*16 +: 16] = 16'(12345 + 777 * j + c);
        coefQ[j*16 +: 16] = 16'(-3000 + 111 * j);
      end
    end
    sendSample(-6000, 2468, 0, "R10");
    check("R10 gain unchanged", int'(outI), -3000);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule